// File: doc/BRIEF.md
# RTU Frame Receiver and Checker

This block sits behind a UART byte receiver on a serial field bus that uses the RTU framing rules. It takes each received byte with a one-cycle valid strobe and a bit-time tick. It finds the frame edges only by timing the line silence in bit ticks. A long silence closes a frame. A medium silence inside a frame marks the frame as broken.

While the bytes arrive, the block updates a running CRC-16 (reflected polynomial 0xA001, start value 0xFFFF, one bit per shift, LSB first). It stores every byte in a buffer that a downstream parser can read. When the frame closes, the block checks the address and the CRC. It then raises a one-cycle done pulse together with the byte count and four result flags: valid frame for this node, valid broadcast, CRC error and framing error. The result is held until the next frame closes.

With the default of 11 bits per character, the 1.5-character limit rounds up to 17 ticks and the 3.5-character limit rounds up to 39 ticks. The idle count is the number of ticks since the last byte strobe. A byte strobe comes at the end of its own character, so the count seen by a following strobe includes that byte's 11 bits. The in-frame gap limit is therefore 11 + 17 = 28 ticks.

Top module: `rtu_frame_rx`

## Requirements
- R1: Reset behaviour. While `rst` is high and after it is released, `frame_done`, `frame_len`, `frame_ok`, `frame_bcast`, `crc_err` and `frm_err` are all 0.
- R2: Frame end. The idle count restarts at each byte strobe and counts `bit_tick` pulses. When it reaches 39, an open frame closes, and `frame_done` is high for exactly that one cycle.
- R3: CRC pass. The frame closes with `frame_ok` = 1 and no error flag when all of these hold:
  - it has at least 4 bytes;
  - the running CRC taken over all of its bytes, including the last two, ends at 0 (the last two bytes being the CRC, low byte then high byte);
  - no framing fault occurred;
  - byte 0 equals `node_addr`, and `node_addr` is in 1..247.
  Example: bytes 01 03 00 00 00 02 C4 0B with `node_addr` = 1.
- R4: CRC failure. A frame of at least 4 bytes whose CRC does not check raises `crc_err`, and `frame_ok` and `frame_bcast` are 0.
- R5: In-frame gap. A byte arriving inside an open frame with an idle count above 28 raises `frm_err` for that frame. A count of exactly 28 is accepted.
- R6: Broadcast. A valid frame whose byte 0 is 0x00 raises `frame_bcast` (a frame that gets no reply) and leaves `frame_ok` at 0.
- R7: Address filter. A valid frame with any other address, including a reserved address 248..255, has `frame_ok` and `frame_bcast` both at 0. A reserved `node_addr` never yields `frame_ok`.
- R8: Short frames. A frame of fewer than 4 bytes raises `frm_err`, and `crc_err` stays 0.
- R9: Overflow. Bytes beyond the 256th are dropped. The frame then raises `frm_err`, and `frame_len` reads 256.
- R10: Buffer read. Byte k of the last frame (k = 0 is the address) appears on `rd_data` one cycle after `rd_addr` = k is presented.
- R11: Length. `frame_len` equals the number of bytes received in the frame, with a maximum of 256.
- R12: Hold. `frame_len` and all four flags change only in the cycle in which `frame_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per serial bit time |
| rx_valid | input | 1 | Received-byte strobe, one cycle |
| rx_data | input | 8 | Received byte |
| node_addr | input | 8 | Address of this node |
| rd_addr | input | 8 | Buffer read index |
| rd_data | output | 8 | Buffer byte, registered |
| frame_done | output | 1 | Frame closed, one cycle |
| frame_len | output | 9 | Byte count of the last frame |
| frame_ok | output | 1 | Valid frame for this node |
| frame_bcast | output | 1 | Valid broadcast frame |
| crc_err | output | 1 | CRC check failed |
| frm_err | output | 1 | Timing, length or overflow fault |

## Verification
The assertions assume three things about the inputs:
- `rx_valid` is a single-cycle strobe;
- `node_addr` does not change while a frame is open;
- reset is applied before any byte.

The bench keeps within these limits. It drives every strobe for one cycle at a falling edge, and it changes `node_addr` only between frames. The tick runs on every cycle, so the spacing between bytes in clock cycles equals the idle count in ticks. This lets the bench place the gaps of 28 and 29 ticks and the 39-tick closing point exactly.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

  typedef struct packed {
    logic ok;
    logic bcast;
    logic crc_bad;
    logic frm_bad;
  } rtu_status_t;

  // one byte of the reflected CRC-16, LSB first, one bit per shift
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      if (r[0]) r = (r >> 1) ^ 16'hA001;
      else      r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
  parameter int CHAR_BITS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic strobe,
  output logic gap_bad,
  output logic eof_hit
);
  localparam int T15     = (3 * CHAR_BITS + 1) / 2;
  localparam int T35     = (7 * CHAR_BITS + 1) / 2;
  localparam int GAP_MAX = CHAR_BITS + T15;
  localparam int CW      = $clog2(T35 + 1);
  localparam logic [CW-1:0] C35  = CW'(T35);
  localparam logic [CW-1:0] C34  = CW'(T35 - 1);
  localparam logic [CW-1:0] CGAP = CW'(GAP_MAX);

  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          idle_cnt <= C35;
    else if (strobe)                  idle_cnt <= '0;
    else if (tick && idle_cnt != C35) idle_cnt <= idle_cnt + 1'b1;
  end

  assign gap_bad = strobe && (idle_cnt > CGAP);
  assign eof_hit = tick && !strobe && (idle_cnt == C34);
endmodule

// File: rtl/rtu_crc16.sv
module rtu_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  logic        first,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  import rtu_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)       crc <= 16'hFFFF;
    else if (step) crc <= crc16_step(first ? 16'hFFFF : crc, data);
  end
endmodule

// File: rtl/rtu_frame_buf.sv
module rtu_frame_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtu_frame_rx.sv
module rtu_frame_rx #(
  parameter int CHAR_BITS   = 11,
  parameter int MAX_LEN     = 256,
  parameter int MIN_FRAME   = 4,
  parameter int MAX_UNICAST = 247,
  parameter int AW          = $clog2(MAX_LEN),
  parameter int LW          = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [7:0]    node_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          frame_done,
  output logic [LW-1:0] frame_len,
  output logic          frame_ok,
  output logic          frame_bcast,
  output logic          crc_err,
  output logic          frm_err
);
  import rtu_pkg::*;

  localparam logic [LW-1:0] LEN_MAX = LW'(MAX_LEN);
  localparam logic [LW-1:0] LEN_MIN = LW'(MIN_FRAME);
  localparam logic [7:0]    UC_TOP  = 8'(MAX_UNICAST);

  logic          active, gap_seen, ovf;
  logic [LW-1:0] len;
  logic [7:0]    addr_q;
  logic [15:0]   crc;
  logic          gap_bad, eof_hit;
  logic          start, buf_we;
  logic [AW-1:0] buf_waddr;
  rtu_status_t   st;

  assign start     = rx_valid && !active;
  assign buf_we    = rx_valid && (!active || len < LEN_MAX);
  assign buf_waddr = active ? len[AW-1:0] : '0;

  rtu_gap_timer #(.CHAR_BITS(CHAR_BITS)) u_gap (
    .clk(clk), .rst(rst), .tick(bit_tick), .strobe(rx_valid),
    .gap_bad(gap_bad), .eof_hit(eof_hit)
  );

  rtu_crc16 u_crc (
    .clk(clk), .rst(rst), .step(rx_valid), .first(start),
    .data(rx_data), .crc(crc)
  );

  rtu_frame_buf #(.DEPTH(MAX_LEN), .AW(AW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(rx_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // verdict of the open frame, taken when the closing silence is reached
  always_comb begin
    logic short_f, clean;
    short_f    = len < LEN_MIN;
    st.crc_bad = !short_f && (crc != 16'h0000);
    st.frm_bad = short_f || gap_seen || ovf;
    clean      = !st.crc_bad && !st.frm_bad;
    st.bcast   = clean && (addr_q == 8'h00);
    st.ok      = clean && (addr_q == node_addr) &&
                 (node_addr != 8'h00) && (node_addr <= UC_TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      gap_seen    <= 1'b0;
      ovf         <= 1'b0;
      len         <= '0;
      addr_q      <= '0;
      frame_done  <= 1'b0;
      frame_len   <= '0;
      frame_ok    <= 1'b0;
      frame_bcast <= 1'b0;
      crc_err     <= 1'b0;
      frm_err     <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        len      <= LW'(1);
        addr_q   <= rx_data;
        gap_seen <= 1'b0;
        ovf      <= 1'b0;
      end else if (rx_valid) begin
        if (gap_bad) gap_seen <= 1'b1;
        if (len == LEN_MAX) ovf <= 1'b1;
        else                len <= len + 1'b1;
      end else if (eof_hit && active) begin
        active      <= 1'b0;
        frame_done  <= 1'b1;
        frame_len   <= len;
        frame_ok    <= st.ok;
        frame_bcast <= st.bcast;
        crc_err     <= st.crc_bad;
        frm_err     <= st.frm_bad;
      end
    end
  end
endmodule

// File: rtl/rtu_frame_rx_chk.sv
module rtu_frame_rx_chk #(
  parameter int MAX_LEN     = 256,
  parameter int MIN_FRAME   = 4,
  parameter int MAX_UNICAST = 247,
  parameter int LW          = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    node_addr,
  input logic          frame_done,
  input logic [LW-1:0] frame_len,
  input logic          frame_ok,
  input logic          frame_bcast,
  input logic          crc_err,
  input logic          frm_err
);
  localparam logic [LW-1:0] LEN_MAX = LW'(MAX_LEN);
  localparam logic [LW-1:0] LEN_MIN = LW'(MIN_FRAME);
  localparam logic [7:0]    UC_TOP  = 8'(MAX_UNICAST);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R2
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> (!crc_err && !frm_err && frame_len >= LEN_MIN)); // R3
  AST_CRC_NOT_OK: assert property (@(posedge clk) disable iff (rst)
    crc_err |-> (!frame_ok && !frame_bcast)); // R4
  AST_BCAST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_bcast)); // R6
  AST_RESERVED_NODE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (node_addr == 8'h00 || node_addr > UC_TOP)) |-> !frame_ok); // R7
  AST_SHORT_NO_CRC: assert property (@(posedge clk) disable iff (rst)
    (frame_done && frame_len < LEN_MIN) |-> (frm_err && !crc_err)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    frame_len <= LEN_MAX); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |-> $stable({frame_len, frame_ok, frame_bcast, crc_err, frm_err})); // R12
endmodule

bind rtu_frame_rx rtu_frame_rx_chk #(
  .MAX_LEN(MAX_LEN), .MIN_FRAME(MIN_FRAME), .MAX_UNICAST(MAX_UNICAST)
) u_chk (
  .clk(clk), .rst(rst), .node_addr(node_addr), .frame_done(frame_done),
  .frame_len(frame_len), .frame_ok(frame_ok), .frame_bcast(frame_bcast),
  .crc_err(crc_err), .frm_err(frm_err)
);

// File: tb/rtu_frame_rx_tb.sv
module rtu_frame_rx_tb;
  localparam int NV = 8;
  // {byte count[3:0], bytes[71:0] first byte high, node[7:0], {ok,bcast,crc,frm}}
  localparam logic [87:0] VEC [NV] = '{
    {4'd8, 72'h01_03_00_00_00_02_C4_0B_00, 8'd1, 4'b1000},
    {4'd8, 72'h01_06_00_17_00_01_F8_0E_00, 8'd1, 4'b1000},
    {4'd8, 72'h01_06_00_17_00_00_39_CE_00, 8'd1, 4'b1000},
    {4'd8, 72'h01_03_00_07_00_11_34_07_00, 8'd1, 4'b1000},
    {4'd9, 72'h01_03_04_12_5D_00_00_6E_99, 8'd1, 4'b1000},
    {4'd8, 72'h01_03_00_00_00_02_C4_0C_00, 8'd1, 4'b0010},
    {4'd8, 72'h01_03_00_00_00_02_C4_0B_00, 8'd2, 4'b0000},
    {4'd3, 72'h01_03_00_00_00_00_00_00_00, 8'd1, 4'b0001}
  };

  logic       clk = 1'b0, rst = 1'b1, bit_tick = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_data = '0, node_addr = 8'd1, rd_addr = '0;
  logic [7:0] rd_data;
  logic       frame_done, frame_ok, frame_bcast, crc_err, frm_err;
  logic [8:0] frame_len;

  int checks = 0, errors = 0;
  logic [7:0] fb [300];
  int fn, done_lat;

  always #4 clk = ~clk;

  rtu_frame_rx u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .node_addr(node_addr), .rd_addr(rd_addr),
    .rd_data(rd_data), .frame_done(frame_done), .frame_len(frame_len),
    .frame_ok(frame_ok), .frame_bcast(frame_bcast), .crc_err(crc_err),
    .frm_err(frm_err)
  );

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {8'h00, fb[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // idle count at the next strobe = wait + 1; spacing 11 by default
  task automatic send_frame(input int gap_at, input int gap_wait);
    for (int i = 0; i < fn; i++) begin
      if (i > 0) repeat ((i == gap_at) ? gap_wait : 10) @(negedge clk);
      send_byte(fb[i]);
    end
    done_lat = 0;
    for (int t = 1; t < 80; t++) begin
      @(negedge clk);
      if (frame_done) begin done_lat = t; break; end
    end
  endtask

  task automatic add_crc();
    logic [15:0] c = ref_crc(fn);
    fb[fn] = c[7:0]; fb[fn+1] = c[15:8]; fn += 2;
  endtask

  task automatic flags(input string req, input logic [3:0] exp);
    check(req, {frame_ok, frame_bcast, crc_err, frm_err}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset flags", {frame_done, frame_ok, frame_bcast, crc_err, frm_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset len", frame_len, 0);

    for (int v = 0; v < NV; v++) begin
      fn = int'(VEC[v][87:84]);
      for (int b = 0; b < fn; b++) fb[b] = VEC[v][83 - 8*b -: 8];
      node_addr = VEC[v][11:4];
      send_frame(-1, 0);
      check($sformatf("R2 done latency v%0d", v), done_lat, 39);
      check($sformatf("R11 length v%0d", v), frame_len, fn);
      flags($sformatf("R3 R4 R7 R8 flags v%0d", v), VEC[v][3:0]);
      repeat (5) @(negedge clk);
    end

    // R12: a CRC-error result stays while the next frame is arriving
    node_addr = 8'd1;
    fn = 8;
    for (int b = 0; b < 8; b++) fb[b] = VEC[5][83 - 8*b -: 8];
    send_frame(-1, 0);
    check("R4 crc error", crc_err, 1);
    send_byte(8'h01); repeat (10) @(negedge clk); send_byte(8'h03);
    check("R12 hold crc_err", crc_err, 1);
    check("R12 hold len", frame_len, 8);
    repeat (50) @(negedge clk);
    check("R8 two-byte frame", {crc_err, frm_err}, 2'b01);

    // R10: buffer readback of the reference frame
    fn = 8;
    for (int b = 0; b < 8; b++) fb[b] = VEC[0][83 - 8*b -: 8];
    send_frame(-1, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) rd_addr = 8'(k);
      @(negedge clk);
      check($sformatf("R10 rd byte %0d", k), rd_data, fb[k]);
    end

    // R5: gap of 28 accepted, 29 rejected
    send_frame(3, 27);
    flags("R5 gap 28 ok", 4'b1000);
    send_frame(3, 28);
    flags("R5 gap 29 frm_err", 4'b0001);

    // R6: broadcast
    fn = 6;
    fb[0] = 8'h00; fb[1] = 8'h06; fb[2] = 8'h00; fb[3] = 8'h17; fb[4] = 8'h00; fb[5] = 8'h01;
    add_crc();
    send_frame(-1, 0);
    flags("R6 broadcast", 4'b0100);

    // R7: reserved address with node set to the same reserved value
    node_addr = 8'hF8;
    fn = 6; fb[0] = 8'hF8;
    add_crc();
    send_frame(-1, 0);
    flags("R7 reserved address", 4'b0000);
    node_addr = 8'd1;

    // R9: 257 bytes, last one dropped
    fn = 257;
    for (int b = 0; b < 257; b++) fb[b] = 8'h55;
    send_frame(-1, 0);
    check("R9 overflow len", frame_len, 256);
    check("R9 overflow frm_err", frm_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule